// File: doc/BRIEF.md
# Hash Sigma and Permutation Unit

This block is a single-operand rotate/XOR functional unit for a scalar cryptographic datapath. It evaluates the four SHA-256 sigma functions (two small, two big) and the two SM3 permutations on the low 32 bits of a source register. The 32-bit result is written into a destination that is either 32 or 64 bits wide. A 64-bit destination receives the result sign-extended from bit 31. In 32-bit mode the upper half of the destination port is zero.

Operands arrive on a valid/ready stream and results leave on a second one. When the `REG_OUT` parameter is 1, one register stage sits between the two streams. A result then appears in the cycle after its operand is accepted. The stage holds its result while the consumer is not ready. In that state `in_ready` is low unless the held result drains in the same cycle. When `REG_OUT` is 0, the unit is purely combinational and `in_ready` follows `out_ready`. An operation whose hash extension is disabled, or whose select code is unused, completes with `illegal` set and a zero destination.

Top module: `hsig_unit`

## Requirements
- R1: Select code 0 returns rotr(x,7) ^ rotr(x,18) ^ (x >> 3), where x is src[31:0].
- R2: Select code 1 returns rotr(x,17) ^ rotr(x,19) ^ (x >> 10).
- R3: Select code 2 returns rotr(x,2) ^ rotr(x,13) ^ rotr(x,22).
- R4: Select code 3 returns rotr(x,6) ^ rotr(x,11) ^ rotr(x,25).
- R5: Select code 4 returns x ^ rotl(x,9) ^ rotl(x,17).
- R6: Select code 5 returns x ^ rotl(x,15) ^ rotl(x,23).
- R7: Bits src[63:32] have no effect on any output.
- R8: With xlen64=1, dst[63:32] repeats bit 31 of the result. With xlen64=0, dst[63:32] is zero.
- R9: If the select code is 6 or 7, or codes 0-3 arrive with sha_en=0, or codes 4-5 arrive with sm3_en=0, then illegal=1 and dst=0. Otherwise illegal=0.
- R10: With REG_OUT=1, out_valid rises in the cycle after an operand is accepted (in_valid && in_ready), and never rises without such an acceptance.
- R11: While out_valid=1 and out_ready=0, dst and illegal hold their values, out_valid stays high and in_ready is low.
- R12: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| src | input | 64 | Source operand; only bits 31:0 are used |
| op | input | 3 | Function select (codes in R1-R6, R9) |
| xlen64 | input | 1 | 1 = 64-bit destination, 0 = 32-bit |
| sha_en | input | 1 | SHA-2 hash functions enabled |
| sm3_en | input | 1 | SM3 permutations enabled |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| dst | output | 64 | Destination value |
| illegal | output | 1 | Operation was not permitted |

## Verification
The bench targets the following corner cases and the fault each one would expose:
- Operands with bit 31 set in 64-bit mode. A unit that zero-extends, or that extends from the wrong bit, returns a wrong upper half.
- Identical low words paired with different upper words. A unit that lets src[63:32] into a rotation produces two different results.
- Every select code under each combination of the enables. A mistaken enable mapping lets through an operation that should be illegal, or blocks one that is legal. A missing zero on an illegal operation leaks a partial result.
- A stalled consumer. A stage that overwrites or drops its held result shows a changed dst, or asserts in_ready while it is full.

// File: rtl/hsig_pkg.sv
package hsig_pkg;
  localparam int WORD_W = 32;
  localparam int DST_W  = 64;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SSIG0 = 3'd0,
    OP_SSIG1 = 3'd1,
    OP_BSIG0 = 3'd2,
    OP_BSIG1 = 3'd3,
    OP_PERM0 = 3'd4,
    OP_PERM1 = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } hsig_op_e;

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] v, input int n);
    logic [2*WORD_W-1:0] d;
    d = {v, v} >> n;
    return d[WORD_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int n);
    return rotr(v, WORD_W - n);
  endfunction
endpackage

// File: rtl/hsig_core.sv
module hsig_core
  import hsig_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [WORD_W-1:0] res_o
);
  logic [WORD_W-1:0] x;
  assign x = word_i;

  always_comb begin
    unique case (hsig_op_e'(op_i))
      OP_SSIG0: res_o = rotr(x, 7)  ^ rotr(x, 18) ^ (x >> 3);
      OP_SSIG1: res_o = rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
      OP_BSIG0: res_o = rotr(x, 2)  ^ rotr(x, 13) ^ rotr(x, 22);
      OP_BSIG1: res_o = rotr(x, 6)  ^ rotr(x, 11) ^ rotr(x, 25);
      OP_PERM0: res_o = x ^ rotl(x, 9)  ^ rotl(x, 17);
      OP_PERM1: res_o = x ^ rotl(x, 15) ^ rotl(x, 23);
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/hsig_fmt.sv
module hsig_fmt
  import hsig_pkg::*;
(
  input  logic [WORD_W-1:0] res_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              xlen64_i,
  input  logic              sha_en_i,
  input  logic              sm3_en_i,
  output logic [DST_W-1:0]  dst_o,
  output logic              illegal_o
);
  localparam int HI_W = DST_W - WORD_W;

  logic is_sha, is_sm3, ok;

  always_comb begin
    is_sha = (op_i <= OP_W'(OP_BSIG1));
    is_sm3 = (op_i == OP_W'(OP_PERM0)) || (op_i == OP_W'(OP_PERM1));
    ok     = (is_sha && sha_en_i) || (is_sm3 && sm3_en_i);
  end

  assign illegal_o = !ok;

  always_comb begin
    if (!ok)           dst_o = '0;
    else if (xlen64_i) dst_o = {{HI_W{res_i[WORD_W-1]}}, res_i};
    else               dst_o = {{HI_W{1'b0}}, res_i};
  end
endmodule

// File: rtl/hsig_stage.sv
module hsig_stage #(
  parameter int W        = 65,
  parameter bit REGISTER = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REGISTER) begin : g_reg
      logic         full_q;
      logic [W-1:0] data_q;

      assign in_ready  = !full_q || out_ready;
      assign out_valid = full_q;
      assign out_data  = data_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          data_q <= '0;
        end else if (in_valid && in_ready) begin
          full_q <= 1'b1;
          data_q <= in_data;
        end else if (out_ready) begin
          full_q <= 1'b0;
        end
      end

      // R11
      stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

      // R11
      full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

      // R10
      rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

      // R10
      accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/hsig_unit.sv
module hsig_unit
  import hsig_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] src,
  input  logic [2:0]  op,
  input  logic        xlen64,
  input  logic        sha_en,
  input  logic        sm3_en,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] dst,
  output logic        illegal
);
  localparam int PAY_W = DST_W + 1;

  logic [WORD_W-1:0] res;
  logic [DST_W-1:0]  fmt_dst;
  logic              fmt_ill;
  logic [PAY_W-1:0]  pay_out;

  hsig_core u_core (
    .word_i (src[WORD_W-1:0]),
    .op_i   (op),
    .res_o  (res)
  );

  hsig_fmt u_fmt (
    .res_i     (res),
    .op_i      (op),
    .xlen64_i  (xlen64),
    .sha_en_i  (sha_en),
    .sm3_en_i  (sm3_en),
    .dst_o     (fmt_dst),
    .illegal_o (fmt_ill)
  );

  hsig_stage #(.W(PAY_W), .REGISTER(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({fmt_ill, fmt_dst}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign illegal = pay_out[PAY_W-1];
  assign dst     = pay_out[DST_W-1:0];

  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (dst == '0));

  // R8
  upper_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((dst[63:32] == 32'h0) || (dst[63:32] == 32'hFFFF_FFFF)));

  // R8
  upper_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dst[63:32] != 32'h0) |-> dst[31]);
endmodule

// File: tb/hsig_unit_bench.sv
module hsig_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] src = '0;
  logic [2:0]  op = '0;
  logic        xlen64 = 1'b0;
  logic        sha_en = 1'b0;
  logic        sm3_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] dst;
  logic        illegal;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hsig_unit u_hsig_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src(src), .op(op), .xlen64(xlen64), .sha_en(sha_en), .sm3_en(sm3_en),
    .out_valid(out_valid), .out_ready(out_ready), .dst(dst), .illegal(illegal)
  );

  function automatic logic [31:0] m_rr(input logic [31:0] v, input int n);
    return (v >> n) | (v << (32 - n));
  endfunction

  function automatic logic [31:0] m_rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [64:0] model(input logic [63:0] s, input logic [2:0] o,
                                        input logic x64, input logic she, input logic sme);
    logic [31:0] x, r;
    logic ok;
    x  = s[31:0];
    ok = (o < 3'd4 && she) || ((o == 3'd4 || o == 3'd5) && sme);
    case (o)
      3'd0: r = m_rr(x, 7)  ^ m_rr(x, 18) ^ (x >> 3);
      3'd1: r = m_rr(x, 17) ^ m_rr(x, 19) ^ (x >> 10);
      3'd2: r = m_rr(x, 2)  ^ m_rr(x, 13) ^ m_rr(x, 22);
      3'd3: r = m_rr(x, 6)  ^ m_rr(x, 11) ^ m_rr(x, 25);
      3'd4: r = x ^ m_rl(x, 9)  ^ m_rl(x, 17);
      3'd5: r = x ^ m_rl(x, 15) ^ m_rl(x, 23);
      default: r = 32'h0;
    endcase
    if (!ok) return {1'b1, 64'h0};
    if (x64 && r[31]) return {1'b0, 32'hFFFF_FFFF, r};
    return {1'b0, 32'h0, r};
  endfunction

  task automatic check(input bit cond, input string req, input logic [64:0] act,
                       input logic [64:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] o, input logic she, input logic sme);
    if (o > 3'd5 || (o < 3'd4 && !she) || (o >= 3'd4 && !sme)) return "R9";
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  logic [64:0] last_got;

  // one operand through the stage with the consumer ready; R10 latency checked
  task automatic send(input logic [63:0] s, input logic [2:0] o, input logic x64,
                      input logic she, input logic sme, input string req);
    logic [64:0] exp;
    @(negedge clk);
    src = s; op = o; xlen64 = x64; sha_en = she; sm3_en = sme;
    in_valid = 1'b1; out_ready = 1'b1;
    exp = model(s, o, x64, she, sme);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    last_got = {illegal, dst};
    check(out_valid == 1'b1, "R10", {64'h0, out_valid}, 65'h1);
    check({illegal, dst} == exp, req, {illegal, dst}, exp);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12
    check(out_valid == 1'b0 && in_ready == 1'b1, "R12", {63'h0, out_valid, in_ready}, 65'h1);

    // directed corners
    send(64'h0000_0000_8000_0000, 3'd0, 1'b1, 1'b1, 1'b1, "R1");
    send(64'hFFFF_FFFF_0000_0001, 3'd1, 1'b1, 1'b1, 1'b1, "R2");
    send(64'h0000_0000_FFFF_FFFF, 3'd2, 1'b0, 1'b1, 1'b0, "R3");
    send(64'h1234_5678_DEAD_BEEF, 3'd3, 1'b1, 1'b1, 1'b0, "R4");
    send(64'h0000_0000_0000_0001, 3'd4, 1'b1, 1'b0, 1'b1, "R5");
    send(64'h0000_0000_8000_0001, 3'd5, 1'b1, 1'b0, 1'b1, "R6");
    send(64'h0000_0000_8765_4321, 3'd6, 1'b1, 1'b1, 1'b1, "R9");
    send(64'h0000_0000_8765_4321, 3'd7, 1'b0, 1'b1, 1'b1, "R9");
    send(64'h0000_0000_8765_4321, 3'd0, 1'b1, 1'b0, 1'b1, "R9");
    send(64'h0000_0000_8765_4321, 3'd5, 1'b1, 1'b1, 1'b0, "R9");
    // R8: same negative result, both widths
    send(64'h0000_0000_C0DE_F00D, 3'd4, 1'b1, 1'b1, 1'b1, "R8");
    send(64'h0000_0000_C0DE_F00D, 3'd4, 1'b0, 1'b1, 1'b1, "R8");

    // R7: upper source bits ignored
    begin
      logic [64:0] a;
      for (int k = 0; k < 6; k++) begin
        send({32'h0000_0000, 32'h9ABC_DEF1}, 3'(k), 1'b1, 1'b1, 1'b1, "R7");
        a = last_got;
        send({32'hA5A5_5A5A, 32'h9ABC_DEF1}, 3'(k), 1'b1, 1'b1, 1'b1, "R7");
        check(last_got == a, "R7", last_got, a);
      end
    end

    // R11: stalled consumer
    begin
      logic [64:0] held;
      @(negedge clk);
      src = 64'h0000_0000_F00D_CAFE; op = 3'd2; xlen64 = 1'b1;
      sha_en = 1'b1; sm3_en = 1'b1; in_valid = 1'b1; out_ready = 1'b0;
      @(posedge clk);
      #1 src = 64'h0000_0000_1111_2222; op = 3'd5;
      @(negedge clk);
      held = {illegal, dst};
      check(held == model(64'h0000_0000_F00D_CAFE, 3'd2, 1'b1, 1'b1, 1'b1), "R11",
            held, model(64'h0000_0000_F00D_CAFE, 3'd2, 1'b1, 1'b1, 1'b1));
      check(in_ready == 1'b0, "R11", {64'h0, in_ready}, 65'h0);
      repeat (3) @(negedge clk);
      check(out_valid == 1'b1 && {illegal, dst} == held, "R11", {illegal, dst}, held);
      check(in_ready == 1'b0, "R11", {64'h0, in_ready}, 65'h0);
      in_valid = 1'b0; out_ready = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R10", {64'h0, out_valid}, 65'h0);
    end

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [63:0] s;
      logic [2:0]  o;
      logic she, sme;
      s   = {$urandom(), $urandom()};
      o   = 3'($urandom_range(0, 7));
      she = ($urandom_range(0, 7) != 0);
      sme = ($urandom_range(0, 7) != 0);
      send(s, o, 1'($urandom_range(0, 1)), she, sme, req_of(o, she, sme));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule